// File: doc/BRIEF.md
# Sequenced reset generator

This block drives the reset and clock-enable lines of a set of subsystems. Software controls it through a simple single-cycle register bus. A channel is released through a timed sequence. The sequence first stops the clock, then holds reset for a programmed number of time-base ticks. It then removes reset while the clock stays stopped for a second programmed number of ticks, restarts the clock and raises a sticky done flag. The ticks come from an external `tick_i` strobe.

There are three kinds of channel:

- **CPU channels.** There are two. Their control words change only under a per-bit write-enable mask. CPU 0 releases itself once the sequence ends. CPU 1 stays in reset until software clears its hold bit. Each CPU control word also carries a cache-flush request, which hardware clears when `flush_ack_i` arrives.
- **Peripheral channels.** These are self-clearing sequenced channels with 8-bit phase periods.
- **Plain reset bits.** A bank of these drive their pins directly. They have no sequencer and no done flag.

Top module: `rst_seq_gen`

Register word addresses:

| Address | Contents |
|---|---|
| 0 | CPU 0 control |
| 1 | CPU 1 control |
| 2 | CPU periods |
| 3 | Peripheral start/done |
| 4 | Plain reset bits |
| 8+i | Periods of peripheral channel i |

## Requirements
- R1: While `rst_ni` is low, every sequenced reset output is 1 and every sequenced clock enable is 0. `sw_rst_o` equals 1<<(NS-1), `flush_req_o` is 0, and every done flag reads 0. After `rst_ni` rises, CPU 0 and all peripheral channels finish a release with zero periods and set their done flags. CPU 1 stays in reset.
- R2: With `tick_i` high every cycle, a sequence started by a write runs with hold period H and release period L. The reset output is 1 for H+2 cycles, and the clock enable is 0 for H+L+3 cycles. The done flag is then set and the start bit reads 0. CPU 0 is started by writing bit 0 together with bit 16 to address 0. Peripheral channel i is started by writing bit i to address 3.
- R3: A phase counts down only in cycles where `tick_i` is 1. With `tick_i` held at 0, a running sequence stalls with reset asserted and the clock gated.
- R4: Address 2 holds the CPU periods, each 4 bits wide: CPU0 hold in [3:0], CPU0 release in [7:4], CPU1 hold in [11:8] and CPU1 release in [15:12]. Address 8+i holds the periods of peripheral i, each 8 bits wide: hold in [7:0] and release in [15:8].
- R5: A start request to a channel whose sequence is running is ignored. While that sequence runs, the channel's start bit reads 1 (bit i at address 3, bit 0 at address 0).
- R6: Done flags are sticky. Writing 1 clears a flag: bit 16+i at address 3 for a peripheral channel, and bit 12 together with enable bit 28 for a CPU channel. Writing 0 leaves a flag set.
- R7: At addresses 0 and 1, write-data bit k in [15:0] takes effect only when bit k+16 of the same write is 1.
- R8: Writing 1 to bit 0 at address 1 puts CPU 1 into a sequence that holds reset for as long as the bit stays 1. Clearing the bit runs the release phase and then sets the done flag (bit 12).
- R9: Writing 1 to bit 4 (with bit 20) at address 0 or 1 raises that CPU's `flush_req_o` bit. Writing 0 to it has no effect. The bit clears on the cycle after the matching `flush_ack_i` bit is 1, and it reads back at bit 4.
- R10: Bit k at address 4 drives `sw_rst_o[k]` directly. Pins 0..NS-2 are active-low resets and pin NS-1 is active-high. The bank reads back at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base strobe, one tick per high cycle |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| flush_ack_i | input | 2 | Flush handshake completion per CPU |
| flush_req_o | output | 2 | Flush request per CPU |
| cpu_rst_o | output | 2 | CPU reset, active high |
| cpu_clk_en_o | output | 2 | CPU clock enable |
| per_rst_o | output | NP | Peripheral reset, active high |
| per_clk_en_o | output | NP | Peripheral clock enable |
| sw_rst_o | output | NS | Plain reset pin levels |

## Verification
The hardest condition to reach from the ports is a start request that lands while the same channel is already mid-sequence. A restart would only show as a longer reset or a longer gated-clock window, not as any flag. The stimulus therefore programs periods of known length and starts the channel. It reads back the busy bit and starts the channel again while the sequence runs. A negedge monitor counts the cycles of asserted reset and gated clock, and these counts are compared with the exact totals predicted for a single sequence. The same cycle counting is applied to randomized periods on random channels, and to a stalled time base.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_GATE_CLK, ST_HOLD_RST, ST_RELEASE_WAIT, ST_UNGATE, ST_DONE
  } seq_state_e;

  localparam int unsigned DATA_W        = 32;
  localparam int unsigned HALF_W        = 16;
  localparam int unsigned CTL_RST_BIT   = 0;
  localparam int unsigned CTL_FLUSH_BIT = 4;
  localparam int unsigned CTL_DONE_BIT  = 12;

  localparam int unsigned A_CPU_BASE = 0;
  localparam int unsigned A_CPU_PER  = 2;
  localparam int unsigned A_PER_CTL  = 3;
  localparam int unsigned A_SW       = 4;
  localparam int unsigned A_PER_BASE = 8;
endpackage

// File: rtl/rsg_flag.sv
module rsg_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set wins over a same-cycle clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o); // R6
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R6
endmodule

// File: rtl/rsg_seq.sv
module rsg_seq
  import rsg_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter bit          MANUAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] hold_per_i,
  input  logic [CNT_W-1:0] rel_per_i,
  output logic             busy_o,
  output logic             rst_o,
  output logic             clk_en_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero, keep_hold;

  assign cnt_zero  = (cnt_q == '0);
  assign keep_hold = MANUAL ? hold_i : 1'b0;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_GATE_CLK;
      ST_GATE_CLK: begin
        state_d = ST_HOLD_RST;
        cnt_d   = hold_per_i;
      end
      ST_HOLD_RST: begin
        if (cnt_zero) begin
          if (!keep_hold) begin
            state_d = ST_RELEASE_WAIT;
            cnt_d   = rel_per_i;
          end
        end else if (tick_i) begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_RELEASE_WAIT: begin
        if (cnt_zero)    state_d = ST_UNGATE;
        else if (tick_i) cnt_d   = cnt_q - ONE;
      end
      ST_UNGATE: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // power-on leaves every channel in reset with an expired hold count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD_RST;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign rst_o    = (state_q == ST_GATE_CLK) || (state_q == ST_HOLD_RST);
  assign clk_en_o = !((state_q == ST_GATE_CLK) || (state_q == ST_HOLD_RST) ||
                      (state_q == ST_RELEASE_WAIT));
  assign done_o   = (state_q == ST_DONE);

  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (state_q != ST_GATE_CLK)); // R5
  AST_DONE_AFTER_UNGATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(state_q) == ST_UNGATE)); // R2
  AST_HOLD_KEEPS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD_RST && !cnt_zero) |=> rst_o); // R2
  AST_NO_TICK_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RELEASE_WAIT && !tick_i && !cnt_zero) |=> $stable(cnt_q)); // R3
  AST_MANUAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_hold && state_q == ST_HOLD_RST) |=> (state_q == ST_HOLD_RST)); // R8
endmodule

// File: rtl/rst_seq_gen.sv
module rst_seq_gen
  import rsg_pkg::*;
#(
  parameter int unsigned NP        = 4,
  parameter int unsigned NS        = 8,
  parameter int unsigned SW_HI_IDX = NS - 1,
  parameter int unsigned CPU_PW    = 4,
  parameter int unsigned PER_PW    = 8,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [1:0]        flush_ack_i,
  output logic [1:0]        flush_req_o,
  output logic [1:0]        cpu_rst_o,
  output logic [1:0]        cpu_clk_en_o,
  output logic [NP-1:0]     per_rst_o,
  output logic [NP-1:0]     per_clk_en_o,
  output logic [NS-1:0]     sw_rst_o
);
  localparam int unsigned NCPU    = 2;
  localparam int unsigned CPER_W  = 2 * NCPU * CPU_PW;
  localparam int unsigned PPER_W  = 2 * PER_PW;
  localparam logic [NS-1:0] SW_INIT = NS'(1) << SW_HI_IDX;

  logic [NCPU-1:0] wr_cpu, cpu_busy, cpu_done_p, cpu_done, flush_q;
  logic [NP-1:0]   per_busy, per_done_p, per_done;
  logic            wr_cper, wr_pctl, wr_sw;
  logic            set_rst, clr_rst, set_flush, set_done;
  logic            cpu1_hold_q;
  logic [CPER_W-1:0] cpu_per_q;
  logic [PPER_W-1:0] per_per_q [NP];
  logic [NS-1:0]   sw_q;
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign wr_cper = wr_i && (addr_i == ADDR_W'(A_CPU_PER));
  assign wr_pctl = wr_i && (addr_i == ADDR_W'(A_PER_CTL));
  assign wr_sw   = wr_i && (addr_i == ADDR_W'(A_SW));

  // masked-write decode: low bit acts only with its enable 16 above
  assign set_rst   = wdata_i[CTL_RST_BIT] && wdata_i[HALF_W+CTL_RST_BIT];
  assign clr_rst   = !wdata_i[CTL_RST_BIT] && wdata_i[HALF_W+CTL_RST_BIT];
  assign set_flush = wdata_i[CTL_FLUSH_BIT] && wdata_i[HALF_W+CTL_FLUSH_BIT];
  assign set_done  = wdata_i[CTL_DONE_BIT] && wdata_i[HALF_W+CTL_DONE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_per_q   <= '0;
      sw_q        <= SW_INIT;
      cpu1_hold_q <= 1'b1;
      for (int i = 0; i < NP; i++) per_per_q[i] <= '0;
    end else begin
      if (wr_cper) cpu_per_q <= wdata_i[CPER_W-1:0];
      if (wr_sw)   sw_q      <= wdata_i[NS-1:0];
      if (wr_cpu[1] && set_rst && !cpu_busy[1]) cpu1_hold_q <= 1'b1;
      else if (wr_cpu[1] && clr_rst)            cpu1_hold_q <= 1'b0;
      for (int i = 0; i < NP; i++)
        if (wr_i && addr_i == ADDR_W'(A_PER_BASE + i))
          per_per_q[i] <= wdata_i[PPER_W-1:0];
    end
  end

  for (genvar k = 0; k < NCPU; k++) begin : g_cpu
    assign wr_cpu[k] = wr_i && (addr_i == ADDR_W'(A_CPU_BASE + k));

    rsg_seq #(.CNT_W(CPU_PW), .MANUAL(k == 1)) u_seq (
      .clk_i, .rst_ni, .tick_i,
      .start_i   (wr_cpu[k] && set_rst && !cpu_busy[k]),
      .hold_i    (cpu1_hold_q),
      .hold_per_i(cpu_per_q[2*k*CPU_PW +: CPU_PW]),
      .rel_per_i (cpu_per_q[(2*k+1)*CPU_PW +: CPU_PW]),
      .busy_o    (cpu_busy[k]),
      .rst_o     (cpu_rst_o[k]),
      .clk_en_o  (cpu_clk_en_o[k]),
      .done_o    (cpu_done_p[k])
    );

    rsg_flag u_done (
      .clk_i, .rst_ni,
      .set_i (cpu_done_p[k]),
      .clr_i (wr_cpu[k] && set_done),
      .flag_o(cpu_done[k])
    );

    // request cleared only by the completion handshake
    rsg_flag u_flush (
      .clk_i, .rst_ni,
      .set_i (wr_cpu[k] && set_flush),
      .clr_i (flush_ack_i[k]),
      .flag_o(flush_q[k])
    );

    AST_FLUSH_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_q[k] && !flush_ack_i[k]) |=> flush_q[k]); // R9
    AST_FLUSH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_q[k] && flush_ack_i[k] && !(wr_cpu[k] && set_flush)) |=> !flush_q[k]); // R9
  end

  for (genvar i = 0; i < NP; i++) begin : g_per
    rsg_seq #(.CNT_W(PER_PW), .MANUAL(1'b0)) u_seq (
      .clk_i, .rst_ni, .tick_i,
      .start_i   (wr_pctl && wdata_i[i] && !per_busy[i]),
      .hold_i    (1'b0),
      .hold_per_i(per_per_q[i][PER_PW-1:0]),
      .rel_per_i (per_per_q[i][PPER_W-1:PER_PW]),
      .busy_o    (per_busy[i]),
      .rst_o     (per_rst_o[i]),
      .clk_en_o  (per_clk_en_o[i]),
      .done_o    (per_done_p[i])
    );

    rsg_flag u_done (
      .clk_i, .rst_ni,
      .set_i (per_done_p[i]),
      .clr_i (wr_pctl && wdata_i[HALF_W+i]),
      .flag_o(per_done[i])
    );
  end

  assign flush_req_o = flush_q;
  assign sw_rst_o    = sw_q;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NCPU; k++) begin
      if (addr_i == ADDR_W'(A_CPU_BASE + k)) begin
        rdata_o[CTL_RST_BIT]   = (k == 1) ? cpu1_hold_q : cpu_busy[k];
        rdata_o[CTL_FLUSH_BIT] = flush_q[k];
        rdata_o[CTL_DONE_BIT]  = cpu_done[k];
      end
    end
    if (addr_i == ADDR_W'(A_CPU_PER)) rdata_o[CPER_W-1:0] = cpu_per_q;
    if (addr_i == ADDR_W'(A_PER_CTL)) begin
      rdata_o[NP-1:0]      = per_busy;
      rdata_o[HALF_W +: NP] = per_done;
    end
    if (addr_i == ADDR_W'(A_SW)) rdata_o[NS-1:0] = sw_q;
    for (int i = 0; i < NP; i++)
      if (addr_i == ADDR_W'(A_PER_BASE + i)) rdata_o[PPER_W-1:0] = per_per_q[i];
  end

  AST_CPU_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cpu[1] && !wdata_i[HALF_W+CTL_RST_BIT]) |=> $stable(cpu1_hold_q)); // R7
  AST_SW_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sw |=> $stable(sw_rst_o)); // R10
endmodule

// File: tb/rst_seq_gen_test.sv
module rst_seq_gen_test;
  localparam int NP = 4;
  localparam int NS = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  flush_ack_i = '0;
  logic [1:0]  flush_req_o, cpu_rst_o, cpu_clk_en_o;
  logic [NP-1:0] per_rst_o, per_clk_en_o;
  logic [NS-1:0] sw_rst_o;

  always #4 clk_i = ~clk_i;

  rst_seq_gen #(.NP(NP), .NS(NS)) uut (
    .clk_i, .rst_ni, .tick_i, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .flush_ack_i, .flush_req_o, .cpu_rst_o, .cpu_clk_en_o,
    .per_rst_o, .per_clk_en_o, .sw_rst_o
  );

  int n_chk = 0, n_bad = 0;
  int mon_kind = 0, mon_idx = 0;
  int cnt_rst = 0, cnt_off = 0;

  always @(negedge clk_i) begin
    if (mon_kind == 0) begin
      if (cpu_rst_o[mon_idx])     cnt_rst++;
      if (!cpu_clk_en_o[mon_idx]) cnt_off++;
    end else begin
      if (per_rst_o[mon_idx])     cnt_rst++;
      if (!per_clk_en_o[mon_idx]) cnt_off++;
    end
  end

  function automatic int exp_rst(input int h);
    return h + 2;
  endfunction
  function automatic int exp_off(input int h, input int l);
    return h + l + 3;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wr_i = 1'b0;
    #1 d = rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    wait_cyc(3);
    // R1 reset state
    chk("R1 cpu_rst", 32'(cpu_rst_o), 32'h3);
    chk("R1 cpu_clk_en", 32'(cpu_clk_en_o), 32'h0);
    chk("R1 per_rst", 32'(per_rst_o), 32'hF);
    chk("R1 per_clk_en", 32'(per_clk_en_o), 32'h0);
    chk("R1 sw_rst", 32'(sw_rst_o), 32'h80);
    chk("R1 flush", 32'(flush_req_o), 32'h0);
    bus_rd(4'd0, d); chk("R1 cpu0 word", d, 32'h1);
    bus_rd(4'd3, d); chk("R1 per word", d, 32'hF);
    @(negedge clk_i) rst_ni = 1'b1;
    wait_cyc(10);
    chk("R1 post cpu_rst", 32'(cpu_rst_o), 32'h2);
    chk("R1 post per_rst", 32'(per_rst_o), 32'h0);
    bus_rd(4'd3, d); chk("R1 post per done", d, 32'h000F_0000);
    bus_rd(4'd0, d); chk("R1 post cpu0 done", d, 32'h1000);
    bus_wr(4'd0, 32'h1000_1000);
    bus_wr(4'd3, 32'h000F_0000);
    bus_rd(4'd0, d); chk("R6 cpu0 clear", d, 32'h0);
    bus_rd(4'd3, d); chk("R6 per clear", d, 32'h0);

    // R7 unmasked write ignored, then R8 manual release
    bus_wr(4'd1, 32'h0000_0000);
    wait_cyc(10);
    chk("R7 cpu1 still held", 32'(cpu_rst_o[1]), 32'h1);
    bus_rd(4'd1, d); chk("R7 cpu1 word", d, 32'h1);
    bus_wr(4'd1, 32'h0001_0000);
    wait_cyc(10);
    chk("R8 cpu1 released", 32'(cpu_rst_o[1]), 32'h0);
    chk("R8 cpu1 clock on", 32'(cpu_clk_en_o[1]), 32'h1);
    bus_rd(4'd1, d); chk("R8 cpu1 done", d, 32'h1000);
    bus_wr(4'd1, 32'h0000_1000);
    bus_rd(4'd1, d); chk("R6 done needs enable", d, 32'h1000);
    bus_wr(4'd1, 32'h1000_1000);
    bus_rd(4'd1, d); chk("R6 done cleared", d, 32'h0);

    // R8 re-hold until software clears
    bus_wr(4'd2, 32'h0000_2300);
    bus_wr(4'd1, 32'h0001_0001);
    wait_cyc(40);
    chk("R8 cpu1 held", 32'(cpu_rst_o[1]), 32'h1);
    bus_rd(4'd1, d); chk("R8 cpu1 word held", d, 32'h1);
    bus_wr(4'd1, 32'h0001_0000);
    wait_cyc(15);
    chk("R8 cpu1 rereleased", 32'(cpu_rst_o[1]), 32'h0);
    bus_rd(4'd1, d); chk("R8 cpu1 done again", d, 32'h1000);
    bus_wr(4'd1, 32'h1000_1000);

    // R2 R4 CPU0 random periods
    for (int it = 0; it < 4; it++) begin
      int h, l;
      h = $urandom % 16; l = $urandom % 16;
      bus_wr(4'd2, 32'h2300 | (l << 4) | h);
      mon_kind = 0; mon_idx = 0; cnt_rst = 0; cnt_off = 0;
      bus_wr(4'd0, 32'h0001_0001);
      wait_cyc(h + l + 10);
      chk("R2 cpu0 reset cycles", cnt_rst, exp_rst(h));
      chk("R4 cpu0 gated cycles", cnt_off, exp_off(h, l));
      bus_rd(4'd0, d); chk("R2 cpu0 done", d, 32'h1000);
      bus_wr(4'd0, 32'h1000_1000);
    end

    // R2 R4 R6 peripheral random periods
    for (int it = 0; it < 10; it++) begin
      int i, h, l;
      i = $urandom % NP; h = $urandom % 256; l = $urandom % 256;
      bus_wr(4'(8 + i), (l << 8) | h);
      mon_kind = 1; mon_idx = i; cnt_rst = 0; cnt_off = 0;
      bus_wr(4'd3, 32'(1) << i);
      wait_cyc(h + l + 10);
      chk("R2 per reset cycles", cnt_rst, exp_rst(h));
      chk("R4 per gated cycles", cnt_off, exp_off(h, l));
      bus_rd(4'd3, d); chk("R2 per done", d, 32'(1) << (16 + i));
      bus_wr(4'd3, 32'(1) << (16 + i));
      bus_rd(4'd3, d); chk("R6 per done clear", d, 32'h0);
    end

    // R5 restart while busy is ignored
    bus_wr(4'd10, 32'h0A0A);
    mon_kind = 1; mon_idx = 2; cnt_rst = 0; cnt_off = 0;
    bus_wr(4'd3, 32'h4);
    bus_rd(4'd3, d); chk("R5 busy readback", d, 32'h4);
    bus_wr(4'd3, 32'h4);
    wait_cyc(40);
    chk("R5 reset cycles unchanged", cnt_rst, exp_rst(10));
    chk("R5 gated cycles unchanged", cnt_off, exp_off(10, 10));
    bus_wr(4'd3, 32'h0004_0000);

    // R3 stalled time base
    bus_wr(4'd9, 32'h0202);
    tick_i = 1'b0;
    bus_wr(4'd3, 32'h2);
    wait_cyc(30);
    chk("R3 stall reset", 32'(per_rst_o[1]), 32'h1);
    chk("R3 stall clock", 32'(per_clk_en_o[1]), 32'h0);
    tick_i = 1'b1;
    wait_cyc(15);
    chk("R3 resumed reset", 32'(per_rst_o[1]), 32'h0);
    bus_rd(4'd3, d); chk("R3 resumed done", d, 32'h0002_0000);
    bus_wr(4'd3, 32'h0002_0000);

    // R9 flush handshake
    bus_wr(4'd0, 32'h0000_0010);
    chk("R7 flush needs enable", 32'(flush_req_o), 32'h0);
    bus_wr(4'd0, 32'h0010_0010);
    chk("R9 flush set", 32'(flush_req_o), 32'h1);
    wait_cyc(20);
    bus_wr(4'd0, 32'h0010_0000);
    chk("R9 flush held", 32'(flush_req_o), 32'h1);
    bus_rd(4'd0, d); chk("R9 flush readback", d, 32'h10);
    flush_ack_i = 2'b01;
    @(negedge clk_i) flush_ack_i = 2'b00;
    chk("R9 flush cleared", 32'(flush_req_o), 32'h0);
    bus_wr(4'd1, 32'h0010_0010);
    chk("R9 cpu1 flush set", 32'(flush_req_o), 32'h2);
    chk("R7 cpu1 hold untouched", 32'(cpu_rst_o[1]), 32'h0);
    flush_ack_i = 2'b10;
    @(negedge clk_i) flush_ack_i = 2'b00;
    bus_rd(4'd1, d); chk("R9 cpu1 flush cleared", d, 32'h0);

    // R10 plain reset bits
    bus_wr(4'd4, 32'h5A);
    chk("R10 sw pins", 32'(sw_rst_o), 32'h5A);
    for (int it = 0; it < 3; it++) begin
      logic [31:0] v;
      v = $urandom & 32'hFF;
      bus_wr(4'd4, v);
      chk("R10 sw random", 32'(sw_rst_o), v);
      bus_rd(4'd4, d); chk("R10 sw readback", d, v);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule